// File: doc/BRIEF.md
# Shifted-Register Logical Execution Unit

This unit executes one instruction word from the logical, shifted-register class of a 64-bit load/store architecture. It splits the word into its fields and sends the two source register indices to the register file read port. It then takes the two operand values that come back and shifts the second one by an immediate amount. It can invert that shifted value before it combines it with the first operand by AND, OR or XOR. The result is written back to the destination register. In 32-bit mode the upper half of the result is zero. The flag-setting AND form also produces new N, Z, C and V condition flags.

The unit assumes the word has already been identified as a member of this class. Bits 28:24 are not examined. The caller pulses `issue` with the word, the operand values and the current flags. One cycle later the outputs hold the destination index, the write enable, the result, the next flag value and a strobe that marks a reserved encoding.

A two-state machine holds the output phase. In ST_IDLE the unit drives no strobes. On `issue` it takes the transition IDLE→DONE and captures the outcome. In ST_DONE `out_valid` is high and the strobes are driven. Another `issue` takes DONE→DONE, so back-to-back words stream at one per cycle. A cycle without `issue` takes DONE→IDLE. IDLE→IDLE holds while nothing is issued.

Top module: `lsr_exec_unit`

## Requirements
- R1: `src_a_idx` equals instruction bits 9:5 and `src_b_idx` equals bits 20:16 in the same cycle, with no register in the path. The captured `rd_idx` is bits 4:0.
- R2: Bits 30:29 select the operation: 00 is AND, 01 is OR, 10 is XOR, and 11 is AND that also updates the flags.
- R3: A source index of 31 reads as zero, whatever value is presented on the matching operand port.
- R4: A destination index of 31 discards the write, so `wr_en` stays low.
- R5: Bits 23:22 select the shift applied to the second operand: 00 is logical left, 01 is logical right, 10 is arithmetic right and 11 is rotate right. The shift amount is bits 15:10, read as an unsigned number.
- R6: Bit 31 = 0 selects 32-bit mode. In this mode the shifts work on the low 32 bits, the rotate wraps around bit 31, the upper operand bits are ignored, and result bits 63:32 are zero. Bit 31 = 1 selects 64-bit operation.
- R7: When bit 21 is 1, the shifted second operand is bitwise inverted before the operation.
- R8: In 32-bit mode, a shift amount with bit 5 set is reserved. The unit raises `illegal` for that word, does not write, and leaves the flags equal to `flags_in`.
- R9: The flag-setting AND gives flags {N,Z,C,V} on bits 3..0. N is the result sign bit (bit 31 in 32-bit mode, bit 63 otherwise). Z is 1 when the result is zero. C and V are both 0.
- R10: The other three operations return `flags_out` equal to the `flags_in` that was issued.
- R11: An OR with source index 31 and shift amount 0 acts as a move: the result is the second operand, or its inverse when bit 21 is 1. An AND with source index 31 gives zero.
- R12: Each `issue` produces exactly one `out_valid` cycle on the next cycle, and issues may follow each other every cycle. `wr_en` and `illegal` are low whenever `out_valid` is low.
- R13: While reset is held, `out_valid`, `wr_en`, `illegal`, `result` and `flags_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Presents an instruction word for execution this cycle |
| instr | input | 32 | Instruction word |
| src_a_idx | output | 5 | First source register index to the register file |
| src_b_idx | output | 5 | Second source register index to the register file |
| src_a_val | input | 64 | Value read for the first source |
| src_b_val | input | 64 | Value read for the second source |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| out_valid | output | 1 | Outputs below belong to the word issued in the previous cycle |
| wr_en | output | 1 | Write the result to register `rd_idx` |
| rd_idx | output | 5 | Destination register index |
| result | output | 64 | Result value |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| illegal | output | 1 | The word used a reserved encoding |

## Verification
Two situations are hard to reach. One is a reserved 32-bit shift amount on the flag-setting AND, where the flags must survive untouched. The other is a zero-register source while the register file returns a non-zero value on that port. The stimulus builds these words field by field. It places non-zero values on both operand ports, drives distinctive flag inputs and puts non-zero data in the upper operand halves. A constant or a flag that leaks through is then visible at `result` and `flags_out`. A long back-to-back run of random words follows, so successive results pass through the output stage with no idle cycles between them.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    localparam int REG_IDX_W = 5;
    localparam logic [REG_IDX_W-1:0] ZERO_REG = 5'd31;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    typedef enum logic [1:0] {
        LOP_AND  = 2'b00,
        LOP_OR   = 2'b01,
        LOP_XOR  = 2'b10,
        LOP_ANDF = 2'b11
    } lop_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_e;

    typedef struct packed {
        logic                 wide;
        lop_e                 op;
        shift_e               sh;
        logic                 inv;
        logic [5:0]           amt;
        logic [REG_IDX_W-1:0] rd;
        logic [REG_IDX_W-1:0] rn;
        logic [REG_IDX_W-1:0] rm;
    } lsr_dec_t;

endpackage

// File: rtl/lsr_decode.sv
module lsr_decode
    import lsr_pkg::*;
(
    input  logic [31:0] instr,
    output lsr_dec_t    dec,
    output logic        reserved
);

    logic class_bits_unused;

    always_comb begin
        dec.wide = instr[31];
        dec.op   = lop_e'(instr[30:29]);
        dec.sh   = shift_e'(instr[23:22]);
        dec.inv  = instr[21];
        dec.rm   = instr[20:16];
        dec.amt  = instr[15:10];
        dec.rn   = instr[9:5];
        dec.rd   = instr[4:0];
    end

    // 32-bit operation cannot use a shift amount of 32 or more
    assign reserved = !dec.wide && dec.amt[5];

    assign class_bits_unused = ^instr[28:24];

endmodule

// File: rtl/lsr_shifter.sv
module lsr_shifter
    import lsr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]         val,
    input  logic                    wide,
    input  shift_e                  sh,
    input  logic [$clog2(XLEN)-1:0] amt,
    output logic [XLEN-1:0]         out
);

    localparam int HALF  = XLEN / 2;
    localparam int LANES = 2;

    logic [XLEN-1:0] lane_res [LANES];

    // lane 0 works on the low half, lane 1 on the full width
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int W  = (g == 0) ? HALF : XLEN;
        localparam int AW = $clog2(W);
        localparam logic [AW:0] WL = W;

        logic [W-1:0]  v;
        logic [AW-1:0] a;
        logic [W-1:0]  r;

        assign v = val[W-1:0];
        assign a = amt[AW-1:0];

        always_comb begin
            unique case (sh)
                SH_LSL: r = v << a;
                SH_LSR: r = v >> a;
                SH_ASR: r = $signed(v) >>> a;
                SH_ROR: r = (v >> a) | (v << (WL - {1'b0, a}));
            endcase
        end

        assign lane_res[g] = XLEN'(r);
    end

    assign out = wide ? lane_res[1] : lane_res[0];

endmodule

// File: rtl/lsr_alu.sv
module lsr_alu
    import lsr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb_sh,
    input  logic            inv,
    input  lop_e            op,
    input  logic            wide,
    input  logic [3:0]      flags_in,
    output logic [XLEN-1:0] res,
    output logic [3:0]      flags_nx
);

    localparam int HALF = XLEN / 2;
    localparam logic [XLEN-1:0] LOW_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};

    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] raw;
    logic            sign;

    always_comb begin
        opb = inv ? ~opb_sh : opb_sh;
        unique case (op)
            LOP_AND, LOP_ANDF: raw = opa & opb;
            LOP_OR:            raw = opa | opb;
            LOP_XOR:           raw = opa ^ opb;
        endcase
        res  = wide ? raw : (raw & LOW_MASK);
        sign = wide ? res[XLEN-1] : res[HALF-1];

        flags_nx = flags_in;
        if (op == LOP_ANDF) begin
            flags_nx[FLAG_N] = sign;
            flags_nx[FLAG_Z] = (res == '0);
            flags_nx[FLAG_C] = 1'b0;
            flags_nx[FLAG_V] = 1'b0;
        end
    end

endmodule

// File: rtl/lsr_exec_unit.sv
module lsr_exec_unit
    import lsr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            issue,
    input  logic [31:0]     instr,
    output logic [4:0]      src_a_idx,
    output logic [4:0]      src_b_idx,
    input  logic [XLEN-1:0] src_a_val,
    input  logic [XLEN-1:0] src_b_val,
    input  logic [3:0]      flags_in,
    output logic            out_valid,
    output logic            wr_en,
    output logic [4:0]      rd_idx,
    output logic [XLEN-1:0] result,
    output logic [3:0]      flags_out,
    output logic            illegal
);

    localparam int AMT_W = $clog2(XLEN);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } state_e;

    lsr_dec_t        dec;
    logic            reserved;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] opb_sh;
    logic [XLEN-1:0] alu_res;
    logic [3:0]      alu_flags;

    state_e          state_q, state_d;
    logic [4:0]      rd_q;
    logic [XLEN-1:0] res_q;
    logic [3:0]      flags_q;
    logic            rsv_q;

    lsr_decode u_dec (
        .instr    (instr),
        .dec      (dec),
        .reserved (reserved)
    );

    assign src_a_idx = dec.rn;
    assign src_b_idx = dec.rm;

    // index 31 is the zero register for this instruction class
    assign opa = (dec.rn == ZERO_REG) ? '0 : src_a_val;
    assign opb = (dec.rm == ZERO_REG) ? '0 : src_b_val;

    lsr_shifter #(.XLEN(XLEN)) u_shift (
        .val  (opb),
        .wide (dec.wide),
        .sh   (dec.sh),
        .amt  (dec.amt[AMT_W-1:0]),
        .out  (opb_sh)
    );

    lsr_alu #(.XLEN(XLEN)) u_alu (
        .opa      (opa),
        .opb_sh   (opb_sh),
        .inv      (dec.inv),
        .op       (dec.op),
        .wide     (dec.wide),
        .flags_in (flags_in),
        .res      (alu_res),
        .flags_nx (alu_flags)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = issue ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = issue ? ST_DONE : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= '0;
            res_q   <= '0;
            flags_q <= '0;
            rsv_q   <= 1'b0;
        end else if (issue) begin
            rd_q    <= dec.rd;
            res_q   <= reserved ? '0 : alu_res;
            flags_q <= reserved ? flags_in : alu_flags;
            rsv_q   <= reserved;
        end
    end

    always_comb begin
        rd_idx    = rd_q;
        result    = res_q;
        flags_out = flags_q;
        unique case (state_q)
            ST_IDLE: begin
                out_valid = 1'b0;
                wr_en     = 1'b0;
                illegal   = 1'b0;
            end
            ST_DONE: begin
                out_valid = 1'b1;
                wr_en     = !rsv_q && (rd_q != ZERO_REG);
                illegal   = rsv_q;
            end
        endcase
    end

endmodule

// File: rtl/lsr_exec_checker.sv
module lsr_exec_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue,
    input logic [31:0]     instr,
    input logic [3:0]      flags_in,
    input logic            out_valid,
    input logic            wr_en,
    input logic [4:0]      rd_idx,
    input logic [XLEN-1:0] result,
    input logic [3:0]      flags_out,
    input logic            illegal
);

    localparam int HALF = XLEN / 2;

    logic instr_unused;
    assign instr_unused = ^{instr[28:16], instr[14:0]};

    AST_STROBES_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!wr_en && !illegal)); // R12
    AST_VALID_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(issue)); // R12
    AST_ISSUE_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> out_valid); // R12
    AST_ZERO_REG_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (rd_idx != 5'd31)); // R4
    AST_RESERVED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_en); // R8
    AST_RESERVED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !instr[31] && instr[15]) |=> illegal); // R8
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(instr[31])) |-> (result[XLEN-1:HALF] == '0)); // R6
    AST_CV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !illegal && $past(instr[30:29]) == 2'b11)
        |-> (flags_out[1:0] == 2'b00)); // R9
    AST_Z_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !illegal && $past(instr[30:29]) == 2'b11)
        |-> (flags_out[2] == (result == '0))); // R9
    AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(instr[30:29]) != 2'b11)
        |-> (flags_out == $past(flags_in))); // R10

endmodule

bind lsr_exec_unit lsr_exec_checker #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .instr     (instr),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .wr_en     (wr_en),
    .rd_idx    (rd_idx),
    .result    (result),
    .flags_out (flags_out),
    .illegal   (illegal)
);

// File: tb/tb_lsr_exec_unit.sv
`timescale 1ns/1ps
module tb_lsr_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [31:0] instr = '0;
    logic [4:0]  src_a_idx, src_b_idx;
    logic [63:0] src_a_val = '0, src_b_val = '0;
    logic [3:0]  flags_in = '0;
    logic        out_valid, wr_en, illegal;
    logic [4:0]  rd_idx;
    logic [63:0] result;
    logic [3:0]  flags_out;

    int n_chk = 0;
    int n_bad = 0;
    int n_push = 0;
    int n_pop = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    lsr_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .src_a_val(src_a_val), .src_b_val(src_b_val), .flags_in(flags_in),
        .out_valid(out_valid), .wr_en(wr_en), .rd_idx(rd_idx),
        .result(result), .flags_out(flags_out), .illegal(illegal)
    );

    typedef struct {
        logic        wr;
        logic [4:0]  rd;
        logic [63:0] res;
        logic [3:0]  fl;
        logic        ill;
        string       req;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic wide, input logic [1:0] opc,
                                       input logic inv, input logic [1:0] sh,
                                       input logic [5:0] amt, input logic [4:0] rm,
                                       input logic [4:0] rn, input logic [4:0] rd);
        return {wide, opc, 5'b01010, sh, inv, rm, amt, rn, rd};
    endfunction

    function automatic exp_t model(input logic [31:0] ins, input logic [63:0] av,
                                   input logic [63:0] bv, input logic [3:0] fin);
        exp_t        e;
        logic        wide;
        logic [5:0]  amt;
        logic [4:0]  a5;
        logic [63:0] a, b, s, r;
        logic [31:0] y, t;
        wide = ins[31];
        amt  = ins[15:10];
        a5   = amt[4:0];
        a    = (ins[9:5] == 5'd31) ? 64'd0 : av;
        b    = (ins[20:16] == 5'd31) ? 64'd0 : bv;
        if (wide) begin
            case (ins[23:22])
                2'd0: s = b << amt;
                2'd1: s = b >> amt;
                2'd2: s = $signed(b) >>> amt;
                default: s = (b >> amt) | (b << (64 - amt));
            endcase
        end else begin
            y = b[31:0];
            case (ins[23:22])
                2'd0: t = y << a5;
                2'd1: t = y >> a5;
                2'd2: t = $signed(y) >>> a5;
                default: t = (y >> a5) | (y << (32 - a5));
            endcase
            s = {32'd0, t};
        end
        if (ins[21]) s = ~s;
        case (ins[30:29])
            2'd1: r = a | s;
            2'd2: r = a ^ s;
            default: r = a & s;
        endcase
        if (!wide) r[63:32] = '0;
        e.ill = !wide && amt[5];
        e.rd  = ins[4:0];
        e.wr  = !e.ill && (ins[4:0] != 5'd31);
        e.res = r;
        if (!e.ill && ins[30:29] == 2'd3)
            e.fl = {(wide ? r[63] : r[31]), (r == 64'd0), 2'b00};
        else
            e.fl = fin;
        return e;
    endfunction

    task automatic send(input logic [31:0] ins, input logic [63:0] av,
                        input logic [63:0] bv, input logic [3:0] fin,
                        input string req);
        exp_t e;
        @(negedge clk);
        issue = 1'b1; instr = ins; src_a_val = av; src_b_val = bv; flags_in = fin;
        e = model(ins, av, bv, fin);
        e.req = req;
        sb.push_back(e);
        n_push++;
        #1;
        chk(src_a_idx == ins[9:5], "R1", "src_a_idx", 64'(src_a_idx), 64'(ins[9:5]));
        chk(src_b_idx == ins[20:16], "R1", "src_b_idx", 64'(src_b_idx), 64'(ins[20:16]));
    endtask

    task automatic idle();
        @(negedge clk);
        issue = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R12", "unexpected out_valid", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                n_pop++;
                chk(wr_en == e.wr, e.req, "wr_en", 64'(wr_en), 64'(e.wr));
                chk(rd_idx == e.rd, e.req, "rd_idx", 64'(rd_idx), 64'(e.rd));
                chk(illegal == e.ill, e.req, "illegal", 64'(illegal), 64'(e.ill));
                chk(flags_out == e.fl, e.req, "flags_out", 64'(flags_out), 64'(e.fl));
                if (!e.ill)
                    chk(result == e.res, e.req, "result", result, e.res);
            end
        end else if (rst_n) begin
            if (wr_en || illegal)
                chk(0, "R12", "strobe without out_valid", {62'd0, wr_en, illegal}, 64'd0);
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL R12 watchdog: actual=hung expected=finished");
        summary();
    end

    localparam logic [63:0] VA = 64'hF0F0_1234_8765_00FF;
    localparam logic [63:0] VB = 64'h0FF0_FFFF_9000_FF0F;

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        chk(out_valid == 0, "R13", "out_valid", 64'(out_valid), 64'd0);
        chk(wr_en == 0, "R13", "wr_en", 64'(wr_en), 64'd0);
        chk(illegal == 0, "R13", "illegal", 64'(illegal), 64'd0);
        chk(result == 0, "R13", "result", result, 64'd0);
        chk(flags_out == 0, "R13", "flags_out", 64'(flags_out), 64'd0);
        rst_n = 1'b1;

        // R2 basic operations
        send(mk(1, 2'd0, 0, 2'd0, 6'd0, 5'd2, 5'd1, 5'd3), VA, VB, 4'b0101, "R2");
        send(mk(1, 2'd1, 0, 2'd0, 6'd0, 5'd2, 5'd1, 5'd4), VA, VB, 4'b0101, "R2");
        send(mk(1, 2'd2, 0, 2'd0, 6'd0, 5'd2, 5'd1, 5'd5), VA, VB, 4'b0101, "R2");
        // R9 flag-setting AND: negative, zero, 32-bit sign at bit 31
        send(mk(1, 2'd3, 0, 2'd0, 6'd0, 5'd2, 5'd1, 5'd6),
             64'h8000_0000_0000_0001, 64'h8000_0000_0000_0003, 4'b0011, "R9");
        send(mk(1, 2'd3, 0, 2'd0, 6'd0, 5'd2, 5'd1, 5'd6),
             64'hF0, 64'h0F, 4'b1011, "R9");
        send(mk(0, 2'd3, 0, 2'd0, 6'd0, 5'd2, 5'd1, 5'd6),
             64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_8000_0000, 4'b0011, "R9");
        // R10 flags kept on non-flag ops
        send(mk(1, 2'd1, 0, 2'd0, 6'd0, 5'd2, 5'd1, 5'd7), 64'd0, 64'd0, 4'b1011, "R10");
        send(mk(0, 2'd2, 0, 2'd0, 6'd0, 5'd2, 5'd1, 5'd7), VA, VA, 4'b0110, "R10");
        // R5 shift types, 64-bit
        send(mk(1, 2'd1, 0, 2'd0, 6'd4, 5'd2, 5'd31, 5'd8), VA, VB, 4'd0, "R5");
        send(mk(1, 2'd1, 0, 2'd1, 6'd4, 5'd2, 5'd31, 5'd8), VA, VB, 4'd0, "R5");
        send(mk(1, 2'd1, 0, 2'd2, 6'd4, 5'd2, 5'd31, 5'd8), VA, 64'h8000_0000_0000_1000, 4'd0, "R5");
        send(mk(1, 2'd1, 0, 2'd3, 6'd4, 5'd2, 5'd31, 5'd8), VA, VB, 4'd0, "R5");
        send(mk(1, 2'd1, 0, 2'd3, 6'd63, 5'd2, 5'd31, 5'd8), VA, VB, 4'd0, "R5");
        send(mk(1, 2'd1, 0, 2'd3, 6'd32, 5'd2, 5'd31, 5'd8), VA, VB, 4'd0, "R5");
        // R6 32-bit shifts with dirty upper bits
        send(mk(0, 2'd1, 0, 2'd0, 6'd8, 5'd2, 5'd31, 5'd9), VA, VB, 4'd0, "R6");
        send(mk(0, 2'd1, 0, 2'd1, 6'd8, 5'd2, 5'd31, 5'd9), VA, VB, 4'd0, "R6");
        send(mk(0, 2'd1, 0, 2'd2, 6'd8, 5'd2, 5'd31, 5'd9), VA, VB, 4'd0, "R6");
        send(mk(0, 2'd1, 0, 2'd3, 6'd8, 5'd2, 5'd31, 5'd9), VA, VB, 4'd0, "R6");
        send(mk(0, 2'd2, 0, 2'd3, 6'd31, 5'd2, 5'd1, 5'd9), VA, VB, 4'd0, "R6");
        // R7 inverted second operand
        send(mk(1, 2'd0, 1, 2'd0, 6'd0, 5'd2, 5'd1, 5'd10), VA, VB, 4'd0, "R7");
        send(mk(1, 2'd1, 1, 2'd1, 6'd3, 5'd2, 5'd1, 5'd10), VA, VB, 4'd0, "R7");
        send(mk(0, 2'd2, 1, 2'd0, 6'd0, 5'd2, 5'd1, 5'd10), VA, VB, 4'd0, "R7");
        // R3 zero register as source with non-zero port values
        send(mk(1, 2'd2, 0, 2'd0, 6'd1, 5'd2, 5'd31, 5'd11), VA, VB, 4'd0, "R3");
        send(mk(1, 2'd2, 0, 2'd0, 6'd0, 5'd31, 5'd1, 5'd11), VA, VB, 4'd0, "R3");
        // R4 destination 31
        send(mk(1, 2'd1, 0, 2'd0, 6'd0, 5'd2, 5'd1, 5'd31), VA, VB, 4'd0, "R4");
        // R8 reserved amount in 32-bit, and the same amount legal in 64-bit
        send(mk(0, 2'd3, 0, 2'd0, 6'd32, 5'd2, 5'd1, 5'd12), VA, VB, 4'b1010, "R8");
        send(mk(0, 2'd1, 0, 2'd1, 6'd40, 5'd2, 5'd1, 5'd12), VA, VB, 4'b0101, "R8");
        send(mk(1, 2'd3, 0, 2'd0, 6'd32, 5'd2, 5'd1, 5'd12), VA, VB, 4'b1010, "R8");
        // R11 move forms and AND with zero source
        send(mk(1, 2'd1, 0, 2'd0, 6'd0, 5'd2, 5'd31, 5'd13), VA, VB, 4'd0, "R11");
        send(mk(1, 2'd1, 1, 2'd0, 6'd0, 5'd2, 5'd31, 5'd13), VA, VB, 4'd0, "R11");
        send(mk(0, 2'd1, 1, 2'd0, 6'd0, 5'd2, 5'd31, 5'd13), VA, VB, 4'd0, "R11");
        send(mk(1, 2'd0, 0, 2'd0, 6'd0, 5'd2, 5'd31, 5'd13), VA, VB, 4'd0, "R11");
        send(mk(1, 2'd3, 1, 2'd0, 6'd0, 5'd2, 5'd31, 5'd13), VA, VB, 4'b0010, "R11");

        // R12 single issue followed by idle
        idle();
        send(mk(1, 2'd1, 0, 2'd0, 6'd0, 5'd2, 5'd1, 5'd14), VA, VB, 4'd0, "R12");
        idle();
        @(negedge clk);
        chk(out_valid == 0, "R12", "out_valid after idle", 64'(out_valid), 64'd0);

        // back-to-back random words
        for (int i = 0; i < 300; i++) begin
            send($urandom, {$urandom, $urandom}, {$urandom, $urandom},
                 4'($urandom), "R2");
        end
        idle();
        repeat (3) @(negedge clk);
        chk(n_pop == n_push, "R12", "results per issue", 64'(n_pop), 64'(n_push));
        summary();
    end

endmodule